// File: doc/BRIEF.md
# Two-Level Cache Line Coherence State Controller

This block keeps the coherence state of a small set of cache lines, each tracked at once in a first-level data cache, a first-level instruction cache and a unified second-level cache. For every access it is given the access kind (read or write), the side (data or instruction), the line index, and the cacheability and write-policy signals seen on the bus. From the stored states it works out the new first-level and second-level states and one action for the surrounding cache logic to carry out. The five actions are a single bus read, a burst bus read that fills both levels, a single bus write, a fill of the first level from the second, and a local write to the second level.

Each line state is held as an enumerated value: Invalid, Shared, Exclusive or Modified. The action is raised as a one-cycle strobe on the clock edge that samples the access. Lines are installed Exclusive (write-back) or Shared (write-through) according to the policy inputs. Writes to Shared lines are passed on to the bus. The instruction-side copy only ever holds Invalid or Shared, because the two valid states mean the same thing there. A write request on the instruction side is rejected with an error strobe.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid at every level, all strobes are low and `rsp_valid` is low. State codes on the ports are Invalid=0, Shared=1, Exclusive=2, Modified=3.
- R2: A read that finds the line Invalid in the selected first-level cache and in the second level, with `cache_req` and `cache_ack` both high, raises `bus_burst_rd` and installs the line in both levels.
- R3: A line installed by a fill takes Exclusive when `page_wt` is 0 and `wb_mode` is 1, and Shared in every other combination. The instruction-side first level always installs Shared.
- R4: A read that misses both levels while `cache_req` or `cache_ack` is low raises `bus_single_rd` and leaves both levels Invalid.
- R5: A read that misses the selected first level but hits the second level raises `l1_fill`. The first level takes the policy state of R3, and the second level keeps its state.
- R6: A read that hits the selected first level raises no strobe and changes no state.
- R7: A data write that misses both levels raises `bus_single_wr` and leaves both levels Invalid (no allocation).
- R8: A data write that hits a Shared line raises `bus_single_wr`, and the line stays Shared. Hitting Shared in the first level leaves the second level unchanged; hitting only the second level leaves the first level Invalid.
- R9: A data write that hits an Exclusive or Modified line in the first level raises no strobe and leaves that level Modified. A data write that misses the first level but hits Exclusive or Modified in the second level raises `l2_wr` and leaves the second level Modified.
- R10: An instruction-side write raises only `inst_wr_err`, changes no state and reports the current states. An instruction-side response never reports Modified for the first level.
- R11: On the cycle after an edge that samples `acc_valid` high, `rsp_valid` is high, at most one of the six strobes is high, and the reported states are the line's new states. On every other cycle `rsp_valid` and all strobes are low.
- R12: Each line index keeps its own states; an access to one line leaves every other line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_inst | input | 1 | 1 = instruction side, 0 = data side |
| acc_line | input | LINE_W | Line index |
| cache_req | input | 1 | Processor asks for the line to be cached |
| cache_ack | input | 1 | Bus acknowledges the line is cacheable |
| page_wt | input | 1 | Page attribute requests write-through |
| wb_mode | input | 1 | Bus grants write-back (1) or write-through (0) |
| rsp_valid | output | 1 | Response cycle for the access sampled on the previous edge |
| bus_single_rd | output | 1 | Strobe: single bus read |
| bus_burst_rd | output | 1 | Strobe: burst bus read, fill both levels |
| bus_single_wr | output | 1 | Strobe: single bus write |
| l1_fill | output | 1 | Strobe: fill first level from second level |
| l2_wr | output | 1 | Strobe: local write to second level only |
| inst_wr_err | output | 1 | Strobe: rejected instruction-side write |
| rsp_l1_state | output | 2 | New state of the selected first-level copy |
| rsp_l2_state | output | 2 | New state of the second-level copy |

## Verification
The bench builds the block with the default of eight lines, so it can give every scenario a fresh line and then return to earlier lines to check that their states were kept (R12). With eight lines, one line can be set up through the instruction side and then reached from the data side. This gives the second-level-only hit cases (R5, R8, R9) without any tag logic. Each access is followed by an idle cycle, so the one-cycle timing of the strobes is checked on both sides of every response.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } mesi_e;

    typedef enum logic [2:0] {
        ACT_NONE   = 3'd0,
        ACT_SRD    = 3'd1,
        ACT_BURST  = 3'd2,
        ACT_SWR    = 3'd3,
        ACT_L1FILL = 3'd4,
        ACT_L2WR   = 3'd5
    } act_e;

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int LINE_W    = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] idx,
    input  logic              wr_en,
    input  logic              wr_inst,
    input  mesi_e             l1_nxt,
    input  mesi_e             l2_nxt,
    output mesi_e             l1d_cur,
    output mesi_e             l1i_cur,
    output mesi_e             l2_cur
);

    mesi_e l1d_q [NUM_LINES];
    mesi_e l1i_q [NUM_LINES];
    mesi_e l2_q  [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic hit;
        assign hit = wr_en && (idx == LINE_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                l1d_q[g] <= ST_I;
                l1i_q[g] <= ST_I;
                l2_q[g]  <= ST_I;
            end else if (hit) begin
                if (wr_inst) begin
                    l1i_q[g] <= l1_nxt;
                end else begin
                    l1d_q[g] <= l1_nxt;
                end
                l2_q[g] <= l2_nxt;
            end
        end
    end

    assign l1d_cur = l1d_q[idx];
    assign l1i_cur = l1i_q[idx];
    assign l2_cur  = l2_q[idx];

endmodule

// File: rtl/mesi_next.sv
module mesi_next
    import mesi_pkg::*;
(
    input  logic  is_write,
    input  logic  is_inst,
    input  mesi_e l1_cur,
    input  mesi_e l2_cur,
    input  logic  cache_req,
    input  logic  cache_ack,
    input  logic  page_wt,
    input  logic  wb_mode,
    output mesi_e l1_nxt,
    output mesi_e l2_nxt,
    output act_e  act,
    output logic  err
);

    mesi_e fill_st;
    mesi_e l1_fill_st;
    logic  cacheable;

    assign fill_st    = (!page_wt && wb_mode) ? ST_E : ST_S;
    assign l1_fill_st = is_inst ? ST_S : fill_st;
    assign cacheable  = cache_req && cache_ack;

    always_comb begin
        l1_nxt = l1_cur;
        l2_nxt = l2_cur;
        act    = ACT_NONE;
        err    = 1'b0;
        if (is_write && is_inst) begin
            err = 1'b1;
        end else if (!is_write) begin
            unique case (l1_cur)
                ST_S, ST_E, ST_M: begin
                    act = ACT_NONE;
                end
                default: begin
                    if (l2_cur != ST_I) begin
                        act    = ACT_L1FILL;
                        l1_nxt = l1_fill_st;
                    end else if (cacheable) begin
                        act    = ACT_BURST;
                        l1_nxt = l1_fill_st;
                        l2_nxt = fill_st;
                    end else begin
                        act = ACT_SRD;
                    end
                end
            endcase
        end else begin
            unique case (l1_cur)
                ST_M, ST_E: begin
                    act    = ACT_NONE;
                    l1_nxt = ST_M;
                end
                ST_S: begin
                    act = ACT_SWR;
                end
                default: begin
                    unique case (l2_cur)
                        ST_M, ST_E: begin
                            act    = ACT_L2WR;
                            l2_nxt = ST_M;
                        end
                        default: begin
                            act = ACT_SWR;
                        end
                    endcase
                end
            endcase
        end
    end

endmodule

// File: rtl/mesi_rsp.sv
module mesi_rsp
    import mesi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       take,
    input  act_e       act_in,
    input  logic       err_in,
    input  mesi_e      l1_in,
    input  mesi_e      l2_in,
    output logic       rsp_valid,
    output logic [5:0] strobes,
    output logic [1:0] l1_state,
    output logic [1:0] l2_state
);

    act_e  act_q;
    logic  err_q;
    logic  vld_q;
    mesi_e l1_q;
    mesi_e l2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= ACT_NONE;
            err_q <= 1'b0;
            vld_q <= 1'b0;
            l1_q  <= ST_I;
            l2_q  <= ST_I;
        end else begin
            vld_q <= take;
            act_q <= take ? act_in : ACT_NONE;
            err_q <= take && err_in;
            if (take) begin
                l1_q <= l1_in;
                l2_q <= l2_in;
            end
        end
    end

    // strobe order: single read, burst, single write, L1 fill, L2 write, error
    always_comb begin
        strobes = 6'b000000;
        unique case (act_q)
            ACT_SRD:    strobes[5] = 1'b1;
            ACT_BURST:  strobes[4] = 1'b1;
            ACT_SWR:    strobes[3] = 1'b1;
            ACT_L1FILL: strobes[2] = 1'b1;
            ACT_L2WR:   strobes[1] = 1'b1;
            default:    strobes    = 6'b000000;
        endcase
        strobes[0] = err_q;
    end

    assign rsp_valid = vld_q;
    assign l1_state  = l1_q;
    assign l2_state  = l2_q;

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int LINE_W    = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_inst,
    input  logic [LINE_W-1:0] acc_line,
    input  logic              cache_req,
    input  logic              cache_ack,
    input  logic              page_wt,
    input  logic              wb_mode,
    output logic              rsp_valid,
    output logic              bus_single_rd,
    output logic              bus_burst_rd,
    output logic              bus_single_wr,
    output logic              l1_fill,
    output logic              l2_wr,
    output logic              inst_wr_err,
    output logic [1:0]        rsp_l1_state,
    output logic [1:0]        rsp_l2_state
);

    mesi_e      l1d_cur;
    mesi_e      l1i_cur;
    mesi_e      l2_cur;
    mesi_e      l1_sel;
    mesi_e      l1_nxt;
    mesi_e      l2_nxt;
    act_e       act;
    logic       err;
    logic [5:0] strobes;

    assign l1_sel = acc_inst ? l1i_cur : l1d_cur;

    mesi_line_store #(
        .NUM_LINES (NUM_LINES),
        .LINE_W    (LINE_W)
    ) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (acc_line),
        .wr_en   (acc_valid && !err),
        .wr_inst (acc_inst),
        .l1_nxt  (l1_nxt),
        .l2_nxt  (l2_nxt),
        .l1d_cur (l1d_cur),
        .l1i_cur (l1i_cur),
        .l2_cur  (l2_cur)
    );

    mesi_next i_next (
        .is_write  (acc_write),
        .is_inst   (acc_inst),
        .l1_cur    (l1_sel),
        .l2_cur    (l2_cur),
        .cache_req (cache_req),
        .cache_ack (cache_ack),
        .page_wt   (page_wt),
        .wb_mode   (wb_mode),
        .l1_nxt    (l1_nxt),
        .l2_nxt    (l2_nxt),
        .act       (act),
        .err       (err)
    );

    mesi_rsp i_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (acc_valid),
        .act_in    (act),
        .err_in    (err),
        .l1_in     (l1_nxt),
        .l2_in     (l2_nxt),
        .rsp_valid (rsp_valid),
        .strobes   (strobes),
        .l1_state  (rsp_l1_state),
        .l2_state  (rsp_l2_state)
    );

    assign bus_single_rd = strobes[5];
    assign bus_burst_rd  = strobes[4];
    assign bus_single_wr = strobes[3];
    assign l1_fill       = strobes[2];
    assign l2_wr         = strobes[1];
    assign inst_wr_err   = strobes[0];

endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_valid,
    input logic       acc_write,
    input logic       acc_inst,
    input logic       cache_req,
    input logic       cache_ack,
    input logic       rsp_valid,
    input logic       bus_single_rd,
    input logic       bus_burst_rd,
    input logic       bus_single_wr,
    input logic       l1_fill,
    input logic       l2_wr,
    input logic       inst_wr_err,
    input logic [1:0] rsp_l1_state,
    input logic [1:0] rsp_l2_state
);

    logic [5:0] stb;
    assign stb = {bus_single_rd, bus_burst_rd, bus_single_wr, l1_fill, l2_wr, inst_wr_err};

    a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stb));

    a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rsp_valid);

    a_r11_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!rsp_valid && stb == 6'b0));

    a_r10_inst_write_err: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_inst && acc_write) |=> inst_wr_err);

    a_r10_inst_no_mod: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_inst) |=> (rsp_l1_state != 2'd3));

    a_r7_write_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write) |=> (!bus_single_rd && !bus_burst_rd && !l1_fill));

    a_r4_no_burst_uncached: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !(cache_req && cache_ack)) |=> !bus_burst_rd);

    a_r2_burst_installs: assert property (@(posedge clk) disable iff (!rst_n)
        bus_burst_rd |-> (rsp_l1_state != 2'd0 && rsp_l2_state != 2'd0));

endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_valid     (acc_valid),
    .acc_write     (acc_write),
    .acc_inst      (acc_inst),
    .cache_req     (cache_req),
    .cache_ack     (cache_ack),
    .rsp_valid     (rsp_valid),
    .bus_single_rd (bus_single_rd),
    .bus_burst_rd  (bus_burst_rd),
    .bus_single_wr (bus_single_wr),
    .l1_fill       (l1_fill),
    .l2_wr         (l2_wr),
    .inst_wr_err   (inst_wr_err),
    .rsp_l1_state  (rsp_l1_state),
    .rsp_l2_state  (rsp_l2_state)
);

// File: tb/test_mesi_line_ctrl.sv
module test_mesi_line_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_LINES  = 8;
    localparam int LINE_W     = $clog2(NUM_LINES);

    localparam logic [1:0] SI = 2'd0, SS = 2'd1, SE = 2'd2, SM = 2'd3;
    // {single rd, burst, single wr, l1 fill, l2 wr, err}
    localparam logic [5:0] X_NONE = 6'b000000;
    localparam logic [5:0] X_SRD  = 6'b100000;
    localparam logic [5:0] X_BRST = 6'b010000;
    localparam logic [5:0] X_SWR  = 6'b001000;
    localparam logic [5:0] X_FILL = 6'b000100;
    localparam logic [5:0] X_L2WR = 6'b000010;
    localparam logic [5:0] X_ERR  = 6'b000001;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              acc_valid = 1'b0;
    logic              acc_write = 1'b0;
    logic              acc_inst = 1'b0;
    logic [LINE_W-1:0] acc_line = '0;
    logic              cache_req = 1'b0;
    logic              cache_ack = 1'b0;
    logic              page_wt = 1'b0;
    logic              wb_mode = 1'b0;
    logic              rsp_valid;
    logic              bus_single_rd, bus_burst_rd, bus_single_wr, l1_fill, l2_wr, inst_wr_err;
    logic [1:0]        rsp_l1_state, rsp_l2_state;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mesi_line_ctrl #(.NUM_LINES(NUM_LINES)) i_mesi_line_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .acc_valid     (acc_valid),
        .acc_write     (acc_write),
        .acc_inst      (acc_inst),
        .acc_line      (acc_line),
        .cache_req     (cache_req),
        .cache_ack     (cache_ack),
        .page_wt       (page_wt),
        .wb_mode       (wb_mode),
        .rsp_valid     (rsp_valid),
        .bus_single_rd (bus_single_rd),
        .bus_burst_rd  (bus_burst_rd),
        .bus_single_wr (bus_single_wr),
        .l1_fill       (l1_fill),
        .l2_wr         (l2_wr),
        .inst_wr_err   (inst_wr_err),
        .rsp_l1_state  (rsp_l1_state),
        .rsp_l2_state  (rsp_l2_state)
    );

    function automatic logic [5:0] stb();
        return {bus_single_rd, bus_burst_rd, bus_single_wr, l1_fill, l2_wr, inst_wr_err};
    endfunction

    task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got vld/stb/l1/l2=%b expected %b", req, act, exp);
        end
    endtask

    // one access, then the response cycle and an idle cycle are checked
    task automatic access(input string req, input int line, input bit wr, input bit inst,
                          input bit creq, input bit cack, input bit pwt, input bit wb,
                          input logic [5:0] xstb, input logic [1:0] xl1, input logic [1:0] xl2);
        acc_valid = 1'b1;
        acc_write = wr;
        acc_inst  = inst;
        acc_line  = LINE_W'(line);
        cache_req = creq;
        cache_ack = cack;
        page_wt   = pwt;
        wb_mode   = wb;
        @(negedge clk);
        acc_valid = 1'b0;
        check(req, {rsp_valid, stb(), rsp_l1_state, rsp_l2_state}, {1'b1, xstb, xl1, xl2});
        @(negedge clk);
        check({req, " idle R11"}, {rsp_valid, stb(), 4'b0}, {1'b0, X_NONE, 4'b0});
    endtask

    task automatic t_reset();
        check("R1 reset outputs", {rsp_valid, stb(), rsp_l1_state, rsp_l2_state}, 11'b0);
        access("R1 R4 line0 invalid, no cache req", 0, 0, 0, 0, 1, 0, 1, X_SRD, SI, SI);
        access("R4 ack low", 0, 0, 0, 1, 0, 0, 1, X_SRD, SI, SI);
    endtask

    task automatic t_burst_writeback();
        access("R2 R3 burst write-back", 1, 0, 0, 1, 1, 0, 1, X_BRST, SE, SE);
        access("R6 read hit", 1, 0, 0, 0, 0, 1, 0, X_NONE, SE, SE);
        access("R9 write hit E", 1, 1, 0, 0, 0, 0, 0, X_NONE, SM, SE);
        access("R9 write hit M", 1, 1, 0, 0, 0, 0, 0, X_NONE, SM, SE);
    endtask

    task automatic t_burst_writethrough();
        access("R3 page write-through", 2, 0, 0, 1, 1, 1, 1, X_BRST, SS, SS);
        access("R8 write hit S in L1", 2, 1, 0, 0, 0, 0, 1, X_SWR, SS, SS);
        access("R3 bus write-through", 3, 0, 0, 1, 1, 0, 0, X_BRST, SS, SS);
    endtask

    task automatic t_l2_paths();
        access("R3 R10 inst fill shared", 4, 0, 1, 1, 1, 0, 1, X_BRST, SS, SE);
        access("R5 L1 fill from L2", 4, 0, 0, 0, 0, 0, 1, X_FILL, SE, SE);
        access("R3 R10 inst fill line5", 5, 0, 1, 1, 1, 0, 1, X_BRST, SS, SE);
        access("R9 L2-only write E", 5, 1, 0, 0, 0, 0, 0, X_L2WR, SI, SM);
        access("R9 L2-only write M", 5, 1, 0, 0, 0, 0, 0, X_L2WR, SI, SM);
        access("R5 fill from modified L2", 5, 0, 0, 0, 0, 1, 1, X_FILL, SS, SM);
        access("R3 inst fill line6", 6, 0, 1, 1, 1, 1, 0, X_BRST, SS, SS);
        access("R8 L2-only write S", 6, 1, 0, 0, 0, 0, 1, X_SWR, SI, SS);
    endtask

    task automatic t_write_miss();
        access("R7 write miss", 7, 1, 0, 1, 1, 0, 1, X_SWR, SI, SI);
        access("R7 still invalid after write", 7, 0, 0, 0, 0, 0, 1, X_SRD, SI, SI);
    endtask

    task automatic t_inst_side();
        access("R10 inst write rejected", 4, 1, 1, 1, 1, 0, 1, X_ERR, SS, SE);
        access("R10 inst read hit after err", 4, 0, 1, 0, 0, 0, 1, X_NONE, SS, SE);
        access("R10 inst write on modified data line", 1, 1, 1, 0, 0, 0, 1, X_ERR, SI, SE);
        access("R10 data side unchanged", 1, 0, 0, 0, 0, 0, 1, X_NONE, SM, SE);
    endtask

    task automatic t_independence();
        access("R12 line0 untouched", 0, 0, 0, 0, 0, 0, 1, X_SRD, SI, SI);
        access("R12 line2 kept", 2, 0, 0, 0, 0, 0, 1, X_NONE, SS, SS);
        access("R12 line5 data kept", 5, 0, 0, 0, 0, 0, 1, X_NONE, SS, SM);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got no finish expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_burst_writeback();
        t_burst_writethrough();
        t_l2_paths();
        t_write_miss();
        t_inst_side();
        t_independence();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule